// File: doc/BRIEF.md
# Range-Scaled Second-Order Delta-Sigma Modulator

This block turns a 16-bit converter code and a current-span selection into a one-bit oversampled stream. That stream switches a current source, and an external analog low-pass filter smooths it. The modulator's full scale, a ones density of exactly 1.0, stands for 24 mA. Each supported span is an offset plus a width, both measured in that full scale. The code is multiplied by the span width over 65536 and added to the span offset. Code 0 therefore lands on the bottom of the span, and the all-ones code lands one step below the top.

The scaled level is held in a register with 24 fractional bits. A second-order, one-bit loop then converts that level into a bit density. The loop has two saturating integrators, each with a gain of one half, and the output bit is the sign of the second integrator. A bottom-of-span force input replaces the code with the bottom of the selected span. The stored code is unaffected: when the force is released, the next level comes from the code then present at the input.

Top module: `ds_range_mod`

## Requirements
- R1: `span_i` selects the span: 2'b01 = 4 to 20 mA, 2'b10 = 0 to 20 mA, 2'b11 = 0 to 24 mA, and 2'b00 = the whole 0 to 24 mA modulator range (same as 2'b11).
- R2: With full scale 2^24 units = 24 mA, the level one cycle after the inputs is offset + floor(code*width/65536). The units are rounded to nearest: 4 mA = 2796203, 16 mA = 11184811, 20 mA = 13981013, 24 mA = 16777216. The level always stays below 2^24.
- R3: Code 0 gives exactly the span offset: a density of 1/6 in the 4 to 20 mA span and 0 in the two zero-based spans.
- R4: While `force_low_i` is high, the level is the span offset whatever the code is. After release, the code at the input applies again.
- R5: For a fixed span, a larger code gives a strictly larger level and never a lower ones density.
- R6: Over a 4096-cycle window taken after 256 settling cycles, the number of ones on `bit_o` equals round(level*4096/2^24) within ±6.
- R7: The all-ones code gives full scale minus one code step. In the 0 to 24 mA span the density is within tolerance of 1.0, and the loop stays stable there.
- R8: While `rst` is high, on the cycle after it the integrators are cleared, the level is 0 and `bit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 16 | Converter code, unsigned |
| span_i | input | 2 | Current span selection (see R1) |
| force_low_i | input | 1 | Forces the level to the bottom of the span |
| bit_o | output | 1 | One-bit oversampled output stream |

## Verification
The checker assumes two things about the inputs: they change only between clock edges, and `span_i` uses only its four encodings, which is guaranteed because the field is two bits wide. The monotonicity property is checked only when the span and the force input are the same on two consecutive cycles. The stimulus changes the span, code and force together and then holds them steady for a whole measurement window. The rules therefore apply across each window, and the transitions exercise them at the window edges. Random codes are drawn over the full 16-bit range, and the directed cases cover 0, the all-ones code and forced operation.

// File: rtl/ds_pkg.sv
package ds_pkg;

    // Span selection encodings
    typedef enum logic [1:0] {
        SPAN_FULL = 2'b00,
        SPAN_4_20 = 2'b01,
        SPAN_0_20 = 2'b10,
        SPAN_0_24 = 2'b11
    } span_e;

    // Modulator full scale in milliamps
    localparam int FS_MA = 24;

    // Milliamps converted to fractional units of full scale, rounded to nearest
    function automatic longint ma_units(input int ma, input int frac_w);
        longint num;
        num = (longint'(ma) << frac_w) + longint'(FS_MA / 2);
        return num / longint'(FS_MA);
    endfunction

    // Bottom of the selected span
    function automatic longint span_base(input span_e s, input int frac_w);
        case (s)
            SPAN_4_20: return ma_units(4, frac_w);
            default:   return 64'd0;
        endcase
    endfunction

    // Width of the selected span
    function automatic longint span_width(input span_e s, input int frac_w);
        case (s)
            SPAN_4_20: return ma_units(16, frac_w);
            SPAN_0_20: return ma_units(20, frac_w);
            default:   return ma_units(24, frac_w);
        endcase
    endfunction

endpackage

// File: rtl/ds_scaler.sv
module ds_scaler #(
    parameter int CODE_W = 16,
    parameter int FRAC_W = 24,
    localparam int LVL_W = FRAC_W + 1,
    localparam int PROD_W = CODE_W + LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        span_i,
    input  logic              force_low_i,
    output logic [LVL_W-1:0]  level_o
);
    import ds_pkg::*;

    span_e              span;
    logic [LVL_W-1:0]   base;
    logic [LVL_W-1:0]   width;
    logic [PROD_W-1:0]  prod;
    logic [LVL_W-1:0]   scaled;
    logic [LVL_W-1:0]   level_n;

    always_comb begin
        span    = span_e'(span_i);
        base    = LVL_W'(span_base(span, FRAC_W));
        width   = LVL_W'(span_width(span, FRAC_W));
        prod    = PROD_W'(code_i) * PROD_W'(width);
        scaled  = LVL_W'(prod >> CODE_W);
        level_n = force_low_i ? base : base + scaled;
    end

    always_ff @(posedge clk) begin
        if (rst) level_o <= '0;
        else     level_o <= level_n;
    end
endmodule

// File: rtl/ds_sat_int.sv
module ds_sat_int #(
    parameter int W    = 30,
    parameter int INIT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] delta_i,
    output logic signed [W-1:0] acc_o
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0]   sum;
    logic signed [W-1:0] nxt;

    always_comb begin
        sum = (W+1)'(acc_o) + (W+1)'(delta_i);
        if (sum[W] != sum[W-1]) nxt = sum[W] ? MINV : MAXV;
        else                    nxt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) acc_o <= W'(INIT);
        else     acc_o <= nxt;
    end
endmodule

// File: rtl/ds_mod2.sv
module ds_mod2 #(
    parameter int FRAC_W  = 24,
    parameter int GUARD_W = 5,
    localparam int LVL_W = FRAC_W + 1,
    localparam int I1_W  = FRAC_W + GUARD_W,
    localparam int I2_W  = I1_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_i,
    output logic             bit_o
);
    localparam logic signed [I1_W-1:0] FS1 = {{(GUARD_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
    localparam logic signed [I2_W-1:0] FS2 = I2_W'(FS1);

    logic signed [I1_W-1:0] lvl_s;
    logic signed [I1_W-1:0] i1;
    logic signed [I2_W-1:0] i2;
    logic signed [I1_W-1:0] d1;
    logic signed [I2_W-1:0] d2;
    logic                   q;

    assign q     = ~i2[I2_W-1];
    assign lvl_s = signed'(I1_W'(level_i));

    // Half-gain integrator steps, second state scaled by two
    always_comb begin
        d1 = lvl_s - (q ? FS1 : '0);
        d2 = I2_W'(i1) - (q ? FS2 : -FS2);
    end

    ds_sat_int #(.W(I1_W), .INIT(0)) u_int1 (
        .clk(clk), .rst(rst), .delta_i(d1), .acc_o(i1)
    );

    ds_sat_int #(.W(I2_W), .INIT(-1)) u_int2 (
        .clk(clk), .rst(rst), .delta_i(d2), .acc_o(i2)
    );

    assign bit_o = q;
endmodule

// File: rtl/ds_range_mod.sv
module ds_range_mod #(
    parameter int CODE_W  = 16,
    parameter int FRAC_W  = 24,
    parameter int GUARD_W = 5,
    localparam int LVL_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        span_i,
    input  logic              force_low_i,
    output logic              bit_o
);
    logic [LVL_W-1:0] level;

    ds_scaler #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_scale (
        .clk(clk), .rst(rst), .code_i(code_i), .span_i(span_i),
        .force_low_i(force_low_i), .level_o(level)
    );

    ds_mod2 #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_mod (
        .clk(clk), .rst(rst), .level_i(level), .bit_o(bit_o)
    );
endmodule

// File: rtl/ds_range_mod_chk.sv
module ds_range_mod_chk #(
    parameter int CODE_W = 16,
    parameter int FRAC_W = 24,
    localparam int LVL_W = FRAC_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_i,
    input logic [1:0]        span_i,
    input logic              force_low_i,
    input logic [LVL_W-1:0]  level,
    input logic              bit_o
);
    import ds_pkg::*;

    localparam logic [LVL_W-1:0] FS = LVL_W'(1) << FRAC_W;

    // R4
    force_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(force_low_i)) |->
            level == LVL_W'(span_base(span_e'($past(span_i)), FRAC_W)));

    // R3
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(code_i) == '0) |->
            level == LVL_W'(span_base(span_e'($past(span_i)), FRAC_W)));

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            (level < FS && level >= LVL_W'(span_base(span_e'($past(span_i)), FRAC_W))));

    // R5
    monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(span_i) == $past(span_i, 2) &&
         !$past(force_low_i) && !$past(force_low_i, 2) &&
         $past(code_i) > $past(code_i, 2)) |-> level > $past(level));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (level == '0 && !bit_o));
endmodule

bind ds_range_mod ds_range_mod_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .code_i(code_i), .span_i(span_i),
    .force_low_i(force_low_i), .level(level), .bit_o(bit_o)
);

// File: tb/tb_ds_range_mod.sv
`timescale 1ns/1ps
module tb_ds_range_mod;
    localparam int WIN    = 4096;
    localparam int SETTLE = 256;
    localparam int TOL    = 6;
    localparam int LIMIT  = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_i = '0;
    logic [1:0]  span_i = '0;
    logic        force_low_i = 1'b0;
    logic        bit_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ds_range_mod dut (
        .clk(clk), .rst(rst), .code_i(code_i), .span_i(span_i),
        .force_low_i(force_low_i), .bit_o(bit_o)
    );

    // Requirement constants, rounded to nearest
    function automatic longint units(input int ma);
        return ((longint'(ma) << 24) + 12) / 24;
    endfunction

    function automatic longint exp_level(input logic [1:0] sp, input logic [15:0] cd,
                                         input bit frc);
        longint base, width;
        base  = (sp == 2'b01) ? units(4) : 0;
        width = (sp == 2'b01) ? units(16) : (sp == 2'b10) ? units(20) : units(24);
        return frc ? base : base + ((longint'(cd) * width) >> 16);
    endfunction

    function automatic int exp_ones(input longint lvl);
        return int'((lvl * WIN + (longint'(1) << 23)) >> 24);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic [1:0] sp, input logic [15:0] cd, input bit frc,
                           output int ones);
        @(negedge clk);
        span_i = sp; code_i = cd; force_low_i = frc;
        repeat (SETTLE) @(negedge clk);
        ones = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            ones += int'(bit_o);
        end
    endtask

    task automatic density(input logic [1:0] sp, input logic [15:0] cd, input bit frc,
                           input string req, output int ones);
        int e;
        measure(sp, cd, frc, ones);
        e = exp_ones(exp_level(sp, cd, frc));
        check((ones >= e - TOL) && (ones <= e + TOL), req, ones, e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > LIMIT && !done) begin
                done = 1'b1;
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int o, lo, hi;
        void'($urandom(32'h1d5a7c31));
        // R8: reset state
        repeat (3) @(negedge clk);
        check(bit_o == 1'b0, "R8 bit during reset", bit_o, 0);
        code_i = 16'hffff; span_i = 2'b11;
        @(negedge clk);
        check(bit_o == 1'b0, "R8 bit held in reset", bit_o, 0);
        rst = 1'b0;

        // R3: code 0 at span bottoms
        density(2'b01, 16'h0000, 1'b0, "R3 4-20 code zero", o);
        density(2'b10, 16'h0000, 1'b0, "R3 0-20 code zero", o);
        check(o == 0, "R3 0-20 zero density", o, 0);
        // R7: full-scale code
        density(2'b01, 16'hffff, 1'b0, "R7 4-20 full code", o);
        density(2'b11, 16'hffff, 1'b0, "R7 0-24 full code", o);
        check(o >= WIN - TOL, "R7 0-24 near full density", o, WIN);
        // R1: span encodings
        density(2'b10, 16'h8000, 1'b0, "R1 0-20 mid", o);
        density(2'b00, 16'h8000, 1'b0, "R1 full mid", o);
        density(2'b11, 16'h4000, 1'b0, "R1 0-24 quarter", o);
        // R4: force ignores code, then releases
        density(2'b01, 16'hffff, 1'b1, "R4 force 4-20", o);
        density(2'b11, 16'hffff, 1'b1, "R4 force 0-24", o);
        check(o == 0, "R4 forced zero density", o, 0);
        density(2'b11, 16'hc000, 1'b0, "R4 release restores code", o);
        // R5: ordering of densities
        density(2'b10, 16'd1000, 1'b0, "R5 low code", lo);
        density(2'b10, 16'd60000, 1'b0, "R5 high code", hi);
        check(hi > lo, "R5 density rises with code", hi, lo);
        // R2/R6: random codes and spans
        for (int k = 0; k < 10; k++) begin
            logic [1:0]  sp = 2'($urandom);
            logic [15:0] cd = 16'($urandom);
            density(sp, cd, 1'b0, "R6 R2 random window", o);
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule